// File: doc/BRIEF.md
# Tick-Driven Watchdog with Startup Delay

This block is a watchdog timer run through one byte-wide control register. The low three bits select a setting code. Each code stands for a pair of times: a startup delay and a recurring watchdog period. Bit 3 is a software kick, and any change of its stored value restarts the period. All time is counted in pulses of an external tick strobe, nominally one per second. When a period runs out without a kick, the block raises a reset pulse of fixed length. It then begins the startup phase of the same setting again.

Software uses it by writing a setting code and then toggling bit 3 more often than the period. Settings with a nonzero startup delay start on their own after the delay. Settings without a delay stay idle until the first kick after they are selected. Three codes keep the timer stopped. The reset value selects one of them, so the watchdog is off until software picks a setting.

Top module: `tick_watchdog`

## Requirements
- R1: A write stores wr_data[3:0] (bits 2:0 = setting code, bit 3 = kick bit). rd_data always returns {4'b0000, stored bits 3:0}, so bits 7:4 read as zero.
- R2: After the synchronous active-high reset, rd_data is 8'h03 (code 3, kick bit 0) and wdt_rst is low.
- R3: Codes 3, 0 and 4 stop the timer. No reset pulse is produced while one of them is held, whatever ticks or kicks arrive.
- R4: The settings, as code: (startup delay, period) in seconds, are 1: (3, 3), 2: (60, 1), 5: (0, 1), 6: (0, 10), 7: (60, 10). One second equals TICKS_PER_SEC tick pulses.
- R5: With a nonzero delay, the timer first counts the delay in ticks and then runs the period from zero. Kick edges during the delay are ignored.
- R6: With a zero delay, no time is counted until the first kick edge after the setting is chosen. That edge starts the period from zero.
- R7: A kick edge is a write whose bit 3 differs from the stored bit 3. In the period phase it sets the elapsed count back to zero.
- R8: When period ticks elapse without a kick, wdt_rst rises in the cycle after the expiring tick and stays high for exactly PULSE_CYCLES clock cycles.
- R9: After the pulse, the timer re-enters the startup phase of the held setting: the delay for codes 1, 2 and 7, or waiting for a kick for codes 5 and 6.
- R10: A write that changes bits 2:0 restarts from the startup phase of the new code, even in mid-period or mid-pulse. A kick toggle in that same write does not count.
- R11: A write that leaves bits 3:0 unchanged has no effect on timing.
- R12: Time advances only on tick pulses. Clock cycles without a tick never cause expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: [2:0] setting code, [3] kick bit |
| rd_data | output | 8 | Register contents, upper nibble zero |
| tick | input | 1 | One-cycle time-base strobe |
| wdt_rst | output | 1 | Watchdog reset pulse, active high |

## Verification
The assertions check on every cycle that the upper read bits stay zero and that a write is reflected on the next read. They also check that a pulse never appears while a stopping code is held, that every pulse starts right after a tick, and that a pulse never runs past PULSE_CYCLES or ends early without an intervening write. Only the bench scenarios can show the timing of each table entry. The same goes for the difference between delayed and kick-armed starts, the ignored kick during the delay, the restart after expiry, and the absence of a restart for an unchanged write. The bench checks each of these against the exact cycle in which a pulse is expected.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int TICKS_PER_SEC = 1,
  parameter int PULSE_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick,
  output logic       wdt_rst
);
  localparam int MAX_TICKS = 60 * TICKS_PER_SEC;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  typedef enum logic [2:0] {S_OFF, S_ARM, S_DLY, S_RUN, S_RST} st_t;

  logic [3:0]    ctrl;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;

  function automatic int dly_s(input logic [2:0] c);
    case (c)
      3'd1:       return 3;
      3'd2, 3'd7: return 60;
      default:    return 0;
    endcase
  endfunction

  function automatic int per_s(input logic [2:0] c);
    case (c)
      3'd1:       return 3;
      3'd2, 3'd5: return 1;
      3'd6, 3'd7: return 10;
      default:    return 0;
    endcase
  endfunction

  function automatic st_t entry_of(input logic [2:0] c);
    if (per_s(c) == 0)      return S_OFF;
    else if (dly_s(c) == 0) return S_ARM;
    else                    return S_DLY;
  endfunction

  wire set_chg = wr_en && (wr_data[2:0] != ctrl[2:0]);
  wire kick    = wr_en && (wr_data[3] != ctrl[3]);

  wire [CW-1:0] dly_lim = CW'(dly_s(ctrl[2:0]) * TICKS_PER_SEC);
  wire [CW-1:0] per_lim = CW'(per_s(ctrl[2:0]) * TICKS_PER_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= 4'h3;
      st   <= S_OFF;
      cnt  <= '0;
      pcnt <= '0;
    end else begin
      if (wr_en) ctrl <= wr_data[3:0];
      if (set_chg) begin
        st   <= entry_of(wr_data[2:0]);
        cnt  <= '0;
        pcnt <= '0;
      end else begin
        case (st)
          S_ARM: if (kick) begin
            st  <= S_RUN;
            cnt <= '0;
          end
          S_DLY: if (tick) begin
            if (cnt == dly_lim - CW'(1)) begin
              st  <= S_RUN;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_RUN: begin
            if (kick) cnt <= '0;
            else if (tick) begin
              if (cnt == per_lim - CW'(1)) begin
                st   <= S_RST;
                cnt  <= '0;
                pcnt <= '0;
              end else cnt <= cnt + CW'(1);
            end
          end
          S_RST: begin
            if (pcnt == PW'(PULSE_CYCLES - 1)) begin
              st   <= entry_of(ctrl[2:0]);
              pcnt <= '0;
            end else pcnt <= pcnt + PW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_data = {4'b0000, ctrl};
  assign wdt_rst = (st == S_RST);
endmodule

// File: rtl/tick_watchdog_checks.sv
module tick_watchdog_checks #(
  parameter int PULSE_CYCLES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       tick,
  input logic       wdt_rst
);
  localparam int LW = $clog2(PULSE_CYCLES + 2);
  logic [LW-1:0] plen;

  always_ff @(posedge clk) begin
    if (rst) plen <= '0;
    else if (wdt_rst) plen <= plen + LW'(1);
    else plen <= '0;
  end

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:4] == 4'b0000);

  assert_write_visible_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

  assert_quiet_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    wdt_rst |-> (rd_data[2:0] inside {3'd1, 3'd2, 3'd5, 3'd6, 3'd7}));

  assert_pulse_after_tick_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst) |-> $past(tick));

  assert_pulse_not_long_R8: assert property (@(posedge clk) disable iff (rst)
    !(wdt_rst && plen == LW'(PULSE_CYCLES)));

  assert_pulse_full_or_cut_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst) |-> (plen == LW'(PULSE_CYCLES) || $past(wr_en)));
endmodule

bind tick_watchdog tick_watchdog_checks #(.PULSE_CYCLES(PULSE_CYCLES)) u_checks (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .tick(tick), .wdt_rst(wdt_rst)
);

// File: tb/tb_tick_watchdog.sv
module tb_tick_watchdog;
  localparam int PULSE = 3;

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       tick = 0;
  logic       wdt_rst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int npulse = 0;
  int exp_q[$];
  int rise_cyc = 0;
  logic prev_rst = 0;

  tick_watchdog #(.TICKS_PER_SEC(1), .PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .wdt_rst(wdt_rst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (wdt_rst && !prev_rst) begin
        npulse++;
        rise_cyc = cyc;
        if (exp_q.size() == 0) check("R3/R8 unexpected pulse at cycle", cyc, -1);
        else check("R8 pulse start cycle", cyc, exp_q.pop_front());
      end
      if (!wdt_rst && prev_rst) check("R8 pulse width", cyc - rise_cyc, PULSE);
    end
    prev_rst = wdt_rst;
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n, input bit expect_last);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      if (expect_last && i == n - 1) exp_q.push_back(cyc + 1);
      @(negedge clk);
      tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    check("R2 reset rd_data", rd_data, 8'h03);
    check("R2 reset wdt_rst", wdt_rst, 0);

    wr(8'hF5);
    check("R1 read masks upper bits", rd_data, 8'h05);
    ticks(4, 0);
    check("R6 no count before first kick", npulse, 0);
    wr(8'h0D);
    ticks(1, 1);
    idle(6);
    check("R4 code5 expiry", npulse, 1);
    ticks(3, 0);
    check("R9 zero-delay re-arms waiting for kick", npulse, 1);

    wr(8'h0E);
    ticks(2, 0);
    wr(8'h06);
    ticks(9, 0);
    wr(8'h0E);
    ticks(9, 0);
    check("R7 kick restarts period", npulse, 1);
    wr(8'h0E);
    ticks(1, 1);
    idle(6);
    check("R11 unchanged write keeps timing", npulse, 2);

    wr(8'h09);
    ticks(2, 0);
    wr(8'h01);
    ticks(3, 0);
    ticks(1, 1);
    idle(6);
    check("R5 delay then period, kick in delay ignored", npulse, 3);
    ticks(5, 0);
    ticks(1, 1);
    idle(6);
    check("R9 delay re-entered after pulse", npulse, 4);

    ticks(5, 0);
    wr(8'h0E);
    ticks(12, 0);
    check("R10 code change restarts startup phase", npulse, 4);

    wr(8'h06);
    ticks(5, 0);
    wr(8'h03);
    ticks(15, 0);
    wr(8'h0B);
    ticks(15, 0);
    wr(8'h08);
    wr(8'h00);
    ticks(12, 0);
    wr(8'h04);
    wr(8'h0C);
    ticks(12, 0);
    check("R3 stop codes 3/0/4 never pulse", npulse, 4);
    check("R1 readback", rd_data, 8'h0C);

    wr(8'h02);
    ticks(60, 0);
    ticks(1, 1);
    idle(6);
    check("R4 code2 60s delay then 1s", npulse, 5);

    wr(8'h07);
    ticks(69, 0);
    ticks(1, 1);
    idle(6);
    check("R4 code7 60s delay then 10s", npulse, 6);

    wr(8'h05);
    wr(8'h0D);
    idle(200);
    check("R12 no expiry without ticks", npulse, 6);
    ticks(1, 1);
    idle(6);
    check("R12 tick expires code5", npulse, 7);

    check("R8 all expected pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule